// File: doc/BRIEF.md
# Condition Register File Unit

This block keeps a 32-bit condition register split into eight 4-bit fields. Field 0 sits in the most significant nibble and field 7 in the least significant one. Each field holds four flags. From its most significant bit down they are less-than (LT), greater-than (GT), equal (EQ) and summary-overflow (SO). Bits are addressed by a 5-bit index counted from the most significant end of the register. The index selects field `idx/4` and position `idx%4` inside that field, so index `i` is register bit `31-i`.

Reads are combinational from the stored state:
- one single-bit read port, which returns the addressed flag in bit 0 of a 32-bit word;
- one whole-field read port.

Writes take effect at the next clock edge. Four sources can write:
- a single-bit write;
- a whole-field write;
- an arithmetic-result update of field 0, which does a signed compare against zero and takes SO from an external summary-overflow flag;
- a vector-compare update of field 6 from a 128-bit result.

Decoding which instructions update which field, and evaluating branches, are left to the surrounding pipeline.

Top module: `crf_unit`

## Requirements
- R1: An active-low reset (`rst_n` = 0) clears all 32 register bits to zero. The clear takes effect at once, without waiting for a clock edge.
- R2: Bit index `i` (0..31) maps to register bit `31-i`. Field `f` occupies bits `31-4f` down to `28-4f`. Inside a field, position 0 is LT (nibble bit 3), 1 is GT (bit 2), 2 is EQ (bit 1) and 3 is SO (bit 0).
- R3: `bit_rd_data` carries the addressed bit in bit 0, and its bits 31..1 are always zero. The value comes from the registered state, so a write shows on the read port only after the clock edge that stores it.
- R4: A single-bit write stores only bit 0 of `bit_wr_data` into the addressed bit. Every other register bit stays unchanged.
- R5: `fld_rd_data` returns the nibble of field `fld_rd_sel`. A field write replaces all four bits of field `fld_wr_sel` with `fld_wr_data`.
- R6: An arithmetic update of field 0 sets exactly one of its LT, GT and EQ bits:
  - LT when the result is negative;
  - GT when the result is positive and non-zero;
  - EQ when the result is zero.
- R7: An arithmetic update copies the `so_flag` input into the field 0 SO bit (register bit 28).
- R8: With `arith_wide` = 0, only the low 32 bits of `arith_result` are compared, as a signed value, and bits 63..32 are ignored. With `arith_wide` = 1, all 64 bits are compared as a signed value.
- R9: A vector update of field 6 works as follows:
  - LT (register bit 7) is set exactly when all 128 result bits are one and `vec_ones_test` is 1;
  - EQ (register bit 5) is set exactly when all 128 bits are zero;
  - GT (bit 6) and SO (bit 4) are cleared.
- R10: When several write sources target the same field in one cycle, the field takes its value from one source only. The order is arithmetic update, then vector update, then field write, then single-bit write. Writes that target different fields in the same cycle all take effect.
- R11: In a cycle with no write enable asserted, the register keeps its value, whatever the address and data inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_rd_idx | input | 5 | Bit index for the single-bit read |
| bit_rd_data | output | 32 | Addressed bit in bit 0, other bits zero |
| bit_wr_en | input | 1 | Single-bit write enable |
| bit_wr_idx | input | 5 | Bit index for the single-bit write |
| bit_wr_data | input | 32 | Write data; only bit 0 is used |
| fld_rd_sel | input | 3 | Field number for the field read |
| fld_rd_data | output | 4 | Selected field, as LT GT EQ SO |
| fld_wr_en | input | 1 | Field write enable |
| fld_wr_sel | input | 3 | Field number for the field write |
| fld_wr_data | input | 4 | New field value |
| arith_upd_en | input | 1 | Update field 0 from an arithmetic result |
| arith_wide | input | 1 | 1: compare 64 bits; 0: compare low 32 bits |
| arith_result | input | 64 | Arithmetic result to classify |
| so_flag | input | 1 | Summary-overflow flag from the flag unit |
| vec_upd_en | input | 1 | Update field 6 from a vector compare |
| vec_ones_test | input | 1 | Enable the all-ones test |
| vec_result | input | 128 | Vector compare result, four 32-bit lanes |
| cr_value | output | 32 | Whole register contents |

## Verification
The assertions assume that every enable, index and data input is a known 0 or 1 at each rising edge. The bit-isolation and hold properties assume that the only other write source is a field-level update, which the isolation property excludes in its antecedent.

The bench meets these assumptions as follows:
- it drives every input from reset onward;
- it changes inputs only on falling edges;
- it returns every enable to zero after each operation, so that no request carries into the next test.

Same-field collisions are raised on purpose, one pair of sources at a time. In each case the winning source's value is predictable from R10.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int CR_FIELDS = 8;
    localparam int FIELD_W   = 4;
    localparam int CR_W      = CR_FIELDS * FIELD_W;
    localparam int BI_W      = $clog2(CR_W);
    localparam int FSEL_W    = $clog2(CR_FIELDS);

    // nibble bit positions, most significant first
    localparam int POS_LT = 3;
    localparam int POS_GT = 2;
    localparam int POS_EQ = 1;
    localparam int POS_SO = 0;

    // fields with dedicated update ports
    localparam int ARITH_FIELD = 0;
    localparam int VEC_FIELD   = 6;

    typedef logic [FIELD_W-1:0] crf_nib_t;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_BIT,
        SRC_FIELD,
        SRC_VEC,
        SRC_ARITH
    } crf_src_e;

endpackage

// File: rtl/crf_arith_flags.sv
module crf_arith_flags
    import crf_pkg::*;
#(
    parameter int RES_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic [RES_W-1:0] result,
    input  logic             wide,
    input  logic             so_in,
    output crf_nib_t         flags
);

    logic neg;
    logic zero;

    always_comb begin
        if (wide) begin
            neg  = result[RES_W-1];
            zero = (result == '0);
        end else begin
            neg  = result[NARROW_W-1];
            zero = (result[NARROW_W-1:0] == '0);
        end
        flags         = '0;
        flags[POS_LT] = neg;
        flags[POS_GT] = !neg && !zero;
        flags[POS_EQ] = zero;
        flags[POS_SO] = so_in;
    end

endmodule

// File: rtl/crf_vec_flags.sv
module crf_vec_flags
    import crf_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 32
) (
    input  logic [VEC_W-1:0] vec,
    input  logic             ones_test,
    output crf_nib_t         flags
);

    localparam int LANES = VEC_W / LANE_W;

    logic [LANES-1:0] lane_ones;
    logic [LANES-1:0] lane_zero;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ones[g] = &vec[g*LANE_W +: LANE_W];
        assign lane_zero[g] = ~|vec[g*LANE_W +: LANE_W];
    end

    always_comb begin
        flags         = '0;
        flags[POS_LT] = ones_test && (&lane_ones);
        flags[POS_EQ] = &lane_zero;
    end

endmodule

// File: rtl/crf_bit_read.sv
module crf_bit_read
    import crf_pkg::*;
#(
    parameter int RD_W = 32
) (
    input  logic [CR_W-1:0] cr,
    input  logic [BI_W-1:0] idx,
    output logic [RD_W-1:0] data
);

    // index 0 addresses the most significant register bit
    logic [CR_W-1:0] rev;

    for (genvar g = 0; g < CR_W; g++) begin : g_rev
        assign rev[g] = cr[CR_W-1-g];
    end

    always_comb begin
        data    = '0;
        data[0] = rev[idx];
    end

endmodule

// File: rtl/crf_unit.sv
module crf_unit
    import crf_pkg::*;
#(
    parameter int RD_W     = 32,
    parameter int ARITH_W  = 64,
    parameter int NARROW_W = 32,
    parameter int VEC_W    = 128,
    parameter int LANE_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BI_W-1:0]     bit_rd_idx,
    output logic [RD_W-1:0]     bit_rd_data,
    input  logic                bit_wr_en,
    input  logic [BI_W-1:0]     bit_wr_idx,
    input  logic [RD_W-1:0]     bit_wr_data,
    input  logic [FSEL_W-1:0]   fld_rd_sel,
    output logic [FIELD_W-1:0]  fld_rd_data,
    input  logic                fld_wr_en,
    input  logic [FSEL_W-1:0]   fld_wr_sel,
    input  logic [FIELD_W-1:0]  fld_wr_data,
    input  logic                arith_upd_en,
    input  logic                arith_wide,
    input  logic [ARITH_W-1:0]  arith_result,
    input  logic                so_flag,
    input  logic                vec_upd_en,
    input  logic                vec_ones_test,
    input  logic [VEC_W-1:0]    vec_result,
    output logic [CR_W-1:0]     cr_value
);

    localparam int POS_W = $clog2(FIELD_W);

    logic [CR_FIELDS-1:0][FIELD_W-1:0] cr_q;
    logic [CR_FIELDS-1:0][FIELD_W-1:0] cr_d;

    crf_nib_t arith_nib;
    crf_nib_t vec_nib;

    crf_arith_flags #(
        .RES_W    (ARITH_W),
        .NARROW_W (NARROW_W)
    ) u_arith (
        .result (arith_result),
        .wide   (arith_wide),
        .so_in  (so_flag),
        .flags  (arith_nib)
    );

    crf_vec_flags #(
        .VEC_W  (VEC_W),
        .LANE_W (LANE_W)
    ) u_vec (
        .vec       (vec_result),
        .ones_test (vec_ones_test),
        .flags     (vec_nib)
    );

    crf_bit_read #(
        .RD_W (RD_W)
    ) u_rd (
        .cr   (cr_q),
        .idx  (bit_rd_idx),
        .data (bit_rd_data)
    );

    logic [FSEL_W-1:0] bit_fld;
    logic [POS_W-1:0]  bit_pos;

    assign bit_fld = bit_wr_idx[BI_W-1:POS_W];
    assign bit_pos = ~bit_wr_idx[POS_W-1:0];

    // packed element CR_FIELDS-1 holds field 0 (most significant nibble)
    for (genvar f = 0; f < CR_FIELDS; f++) begin : g_fld
        localparam int SLOT = CR_FIELDS - 1 - f;
        crf_src_e src;
        crf_nib_t merged;

        always_comb begin
            merged          = cr_q[SLOT];
            merged[bit_pos] = bit_wr_data[0];
        end

        always_comb begin
            src = SRC_HOLD;
            if (arith_upd_en && (f == ARITH_FIELD))
                src = SRC_ARITH;
            else if (vec_upd_en && (f == VEC_FIELD))
                src = SRC_VEC;
            else if (fld_wr_en && (fld_wr_sel == FSEL_W'(f)))
                src = SRC_FIELD;
            else if (bit_wr_en && (bit_fld == FSEL_W'(f)))
                src = SRC_BIT;
        end

        always_comb begin
            unique case (src)
                SRC_ARITH: cr_d[SLOT] = arith_nib;
                SRC_VEC:   cr_d[SLOT] = vec_nib;
                SRC_FIELD: cr_d[SLOT] = fld_wr_data;
                SRC_BIT:   cr_d[SLOT] = merged;
                default:   cr_d[SLOT] = cr_q[SLOT];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cr_q <= '0;
        else
            cr_q <= cr_d;
    end

    assign fld_rd_data = cr_q[FSEL_W'(CR_FIELDS-1) - fld_rd_sel];
    assign cr_value    = cr_q;

endmodule

// File: rtl/crf_unit_chk.sv
module crf_unit_chk
    import crf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [BI_W-1:0]   bit_rd_idx,
    input logic [31:0]       bit_rd_data,
    input logic              bit_wr_en,
    input logic [BI_W-1:0]   bit_wr_idx,
    input logic              fld_wr_en,
    input logic              arith_upd_en,
    input logic              so_flag,
    input logic              vec_upd_en,
    input logic [127:0]      vec_result,
    input logic [CR_W-1:0]   cr_value
);

    logic no_field_upd;
    assign no_field_upd = !fld_wr_en && !arith_upd_en && !vec_upd_en;

    AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bit_rd_data[31:1] == '0); // R3

    AST_READ_MATCHES_REG: assert property (@(posedge clk) disable iff (!rst_n)
        bit_rd_data[0] == cr_value[5'd31 - bit_rd_idx]); // R2

    AST_BIT_WRITE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr_en && no_field_upd) |=>
        (((cr_value ^ $past(cr_value)) & ~(32'h1 << (5'd31 - $past(bit_wr_idx)))) == '0)); // R4

    AST_ARITH_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        arith_upd_en |=> $countones(cr_value[31:29]) == 1); // R6

    AST_ARITH_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        arith_upd_en |=> cr_value[28] == $past(so_flag)); // R7

    AST_VEC_CLEARED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        vec_upd_en |=> (cr_value[6] == 1'b0) && (cr_value[4] == 1'b0)); // R9

    AST_VEC_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_upd_en && (vec_result == '0)) |=> cr_value[5]); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_wr_en && no_field_upd) |=> $stable(cr_value)); // R11

endmodule

bind crf_unit crf_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_rd_idx   (bit_rd_idx),
    .bit_rd_data  (bit_rd_data),
    .bit_wr_en    (bit_wr_en),
    .bit_wr_idx   (bit_wr_idx),
    .fld_wr_en    (fld_wr_en),
    .arith_upd_en (arith_upd_en),
    .so_flag      (so_flag),
    .vec_upd_en   (vec_upd_en),
    .vec_result   (vec_result),
    .cr_value     (cr_value)
);

// File: tb/test_crf_unit.sv
`timescale 1ns/1ps
module test_crf_unit;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [4:0]   bit_rd_idx;
    logic [31:0]  bit_rd_data;
    logic         bit_wr_en;
    logic [4:0]   bit_wr_idx;
    logic [31:0]  bit_wr_data;
    logic [2:0]   fld_rd_sel;
    logic [3:0]   fld_rd_data;
    logic         fld_wr_en;
    logic [2:0]   fld_wr_sel;
    logic [3:0]   fld_wr_data;
    logic         arith_upd_en;
    logic         arith_wide;
    logic [63:0]  arith_result;
    logic         so_flag;
    logic         vec_upd_en;
    logic         vec_ones_test;
    logic [127:0] vec_result;
    logic [31:0]  cr_value;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl;

    always #10 clk = ~clk;

    crf_unit i_crf_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_rd_idx    (bit_rd_idx),
        .bit_rd_data   (bit_rd_data),
        .bit_wr_en     (bit_wr_en),
        .bit_wr_idx    (bit_wr_idx),
        .bit_wr_data   (bit_wr_data),
        .fld_rd_sel    (fld_rd_sel),
        .fld_rd_data   (fld_rd_data),
        .fld_wr_en     (fld_wr_en),
        .fld_wr_sel    (fld_wr_sel),
        .fld_wr_data   (fld_wr_data),
        .arith_upd_en  (arith_upd_en),
        .arith_wide    (arith_wide),
        .arith_result  (arith_result),
        .so_flag       (so_flag),
        .vec_upd_en    (vec_upd_en),
        .vec_ones_test (vec_ones_test),
        .vec_result    (vec_result),
        .cr_value      (cr_value)
    );

    function automatic logic [31:0] put_fld(logic [31:0] v, int n, logic [3:0] d);
        v[31-4*n -: 4] = d;
        return v;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bit_wr_en     = 1'b0;
        fld_wr_en     = 1'b0;
        arith_upd_en  = 1'b0;
        vec_upd_en    = 1'b0;
    endtask

    // inputs are set just after a falling edge; one rising edge passes
    task automatic tick();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        chk("R1", "cr after reset", cr_value, 32'h0);
        bit_rd_idx = 5'd0;
        #1;
        chk("R1", "bit read after reset", bit_rd_data, 32'h0);
    endtask

    task automatic t_bit_write();
        bit_wr_en = 1'b1; bit_wr_idx = 5'd0; bit_wr_data = 32'h1;
        tick(); mdl[31] = 1'b1;
        chk("R2", "index 0 is msb", cr_value, mdl);
        bit_wr_en = 1'b1; bit_wr_idx = 5'd5; bit_wr_data = 32'h1;
        tick(); mdl[26] = 1'b1;
        chk("R4", "set index 5", cr_value, mdl);
        bit_wr_en = 1'b1; bit_wr_idx = 5'd5; bit_wr_data = 32'hFFFF_FFFE;
        tick(); mdl[26] = 1'b0;
        chk("R4", "lsb-only clear", cr_value, mdl);
        bit_wr_en = 1'b1; bit_wr_idx = 5'd27; bit_wr_data = 32'h3;
        tick(); mdl[4] = 1'b1;
        chk("R2", "cr6 so position", cr_value, mdl);
        bit_rd_idx = 5'd27; #1;
        chk("R3", "read index 27", bit_rd_data, 32'h1);
        bit_rd_idx = 5'd26; #1;
        chk("R3", "read index 26", bit_rd_data, 32'h0);
        // write and read the same bit in one cycle
        bit_wr_en = 1'b1; bit_wr_idx = 5'd13; bit_wr_data = 32'h1;
        bit_rd_idx = 5'd13; #1;
        chk("R3", "read before edge", bit_rd_data, 32'h0);
        tick(); mdl[18] = 1'b1;
        chk("R3", "read after edge", bit_rd_data, 32'h1);
    endtask

    task automatic t_field();
        fld_wr_en = 1'b1; fld_wr_sel = 3'd3; fld_wr_data = 4'hA;
        tick(); mdl = put_fld(mdl, 3, 4'hA);
        chk("R5", "field 3 write", cr_value, mdl);
        fld_rd_sel = 3'd3; #1;
        chk("R5", "field 3 read", {28'h0, fld_rd_data}, 32'hA);
        fld_rd_sel = 3'd0; #1;
        chk("R5", "field 0 read", {28'h0, fld_rd_data}, {28'h0, mdl[31:28]});
    endtask

    task automatic do_arith(string req, logic [63:0] res, logic wide, logic so, logic [3:0] exp);
        arith_upd_en = 1'b1; arith_result = res; arith_wide = wide; so_flag = so;
        tick(); mdl = put_fld(mdl, 0, exp);
        chk(req, "arith field 0", cr_value, mdl);
    endtask

    task automatic t_arith();
        do_arith("R6", 64'h0000_0000_0000_0005, 1'b1, 1'b0, 4'b0100);
        do_arith("R7", 64'h0000_0000_0000_0005, 1'b1, 1'b1, 4'b0101);
        do_arith("R8", 64'hFFFF_FFFF_0000_0005, 1'b0, 1'b0, 4'b0100);
        do_arith("R8", 64'hFFFF_FFFF_0000_0005, 1'b1, 1'b0, 4'b1000);
        do_arith("R8", 64'h0000_0000_8000_0000, 1'b0, 1'b1, 4'b1001);
        do_arith("R8", 64'h0000_0000_8000_0000, 1'b1, 1'b0, 4'b0100);
        do_arith("R8", 64'h0000_0001_0000_0000, 1'b0, 1'b0, 4'b0010);
        do_arith("R6", 64'h0000_0000_0000_0000, 1'b1, 1'b1, 4'b0011);
    endtask

    task automatic do_vec(logic [127:0] v, logic ones, logic [3:0] exp);
        vec_upd_en = 1'b1; vec_result = v; vec_ones_test = ones;
        tick(); mdl = put_fld(mdl, 6, exp);
        chk("R9", "vec field 6", cr_value, mdl);
    endtask

    task automatic t_vec();
        fld_wr_en = 1'b1; fld_wr_sel = 3'd6; fld_wr_data = 4'hF;
        tick(); mdl = put_fld(mdl, 6, 4'hF);
        chk("R5", "preload field 6", cr_value, mdl);
        do_vec({128{1'b1}}, 1'b1, 4'b1000);
        do_vec({128{1'b1}}, 1'b0, 4'b0000);
        do_vec(128'h0, 1'b1, 4'b0010);
        do_vec(128'h0, 1'b0, 4'b0010);
        do_vec({{96{1'b1}}, 32'hFFFF_FFFE}, 1'b1, 4'b0000);
        do_vec({32'h0, 32'h0, 32'h0100_0000, 32'h0}, 1'b1, 4'b0000);
    endtask

    task automatic t_priority();
        // arithmetic beats bit write into field 0
        arith_upd_en = 1'b1; arith_result = 64'h5; arith_wide = 1'b1; so_flag = 1'b0;
        bit_wr_en = 1'b1; bit_wr_idx = 5'd3; bit_wr_data = 32'h1;
        tick(); mdl = put_fld(mdl, 0, 4'b0100);
        chk("R10", "arith over bit", cr_value, mdl);
        // vector beats field write into field 6
        vec_upd_en = 1'b1; vec_result = 128'h0; vec_ones_test = 1'b0;
        fld_wr_en = 1'b1; fld_wr_sel = 3'd6; fld_wr_data = 4'hD;
        tick(); mdl = put_fld(mdl, 6, 4'b0010);
        chk("R10", "vec over field", cr_value, mdl);
        // field write beats bit write into field 2
        fld_wr_en = 1'b1; fld_wr_sel = 3'd2; fld_wr_data = 4'h6;
        bit_wr_en = 1'b1; bit_wr_idx = 5'd9; bit_wr_data = 32'h0;
        tick(); mdl = put_fld(mdl, 2, 4'h6);
        chk("R10", "field over bit", cr_value, mdl);
        // arithmetic beats field write into field 0
        arith_upd_en = 1'b1; arith_result = 64'h0; arith_wide = 1'b0; so_flag = 1'b0;
        fld_wr_en = 1'b1; fld_wr_sel = 3'd0; fld_wr_data = 4'hF;
        tick(); mdl = put_fld(mdl, 0, 4'b0010);
        chk("R10", "arith over field", cr_value, mdl);
        // different fields both update
        arith_upd_en = 1'b1; arith_result = 64'hFFFF_FFFF_FFFF_FFFF; arith_wide = 1'b1; so_flag = 1'b1;
        bit_wr_en = 1'b1; bit_wr_idx = 5'd20; bit_wr_data = 32'h1;
        fld_wr_en = 1'b1; fld_wr_sel = 3'd7; fld_wr_data = 4'h9;
        tick(); mdl = put_fld(mdl, 0, 4'b1001); mdl[11] = 1'b1; mdl = put_fld(mdl, 7, 4'h9);
        chk("R10", "three fields at once", cr_value, mdl);
    endtask

    task automatic t_hold();
        bit_wr_idx = 5'd1; bit_wr_data = 32'hFFFF_FFFF;
        fld_wr_sel = 3'd1; fld_wr_data = 4'hF;
        arith_result = 64'h0; vec_result = 128'h0;
        repeat (3) tick();
        chk("R11", "hold with enables low", cr_value, mdl);
    endtask

    task automatic t_reset_again();
        rst_n = 1'b0; #1;
        mdl = 32'h0;
        chk("R1", "async clear mid-run", cr_value, mdl);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1", "still clear after release", cr_value, mdl);
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        bit_rd_idx = '0; bit_wr_idx = '0; bit_wr_data = '0;
        fld_rd_sel = '0; fld_wr_sel = '0; fld_wr_data = '0;
        arith_wide = 1'b0; arith_result = '0; so_flag = 1'b0;
        vec_ones_test = 1'b0; vec_result = '0;
        mdl = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bit_write();
        t_field();
        t_arith();
        t_vec();
        t_priority();
        t_hold();
        t_reset_again();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule